// File: doc/BRIEF.md
# DMA Burst Boundary Splitter

This block turns one DMA burst request into the bus transactions that carry it. A command gives a start address, a transfer width (byte, halfword or word), a burst length in beats and a flag that selects incrementing or fixed addressing. For every command the block issues one or two transactions. Each transaction carries a start address and a beat count, and each is offered through a valid/ready handshake.

With incrementing addressing the block treats every multiple of the burst size in bytes (beats times width) as a boundary that a single transaction must not cross. A burst whose start address is not on such a boundary crosses exactly one of them. That burst is cut there: the head piece runs up to the boundary and the tail piece starts on it. A burst that starts on a boundary goes out whole. Fixed addressing never splits, and its address stays the same. There is no wrapping address mode. When the last piece has been accepted, the block raises a one-cycle completion pulse and presents the address that follows the burst. It accepts a new command only when it is idle.

Top module: `dma_burst_splitter`

## Requirements
- R1: After reset, cmd_ready is 1 and txn_valid and done_valid are both 0.
- R2: cmd_size encodes the width: 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. cmd_len encodes the beat count: code 0 is 1 beat and code n (1 to 7) is 2^(n+1) beats, so the set of lengths is 1, 4, 8, 16, 32, 64, 128 and 256.
- R3: With incrementing addressing and a start address that is a multiple of beats×width, exactly one transaction is issued, at the start address, carrying the full beat count, with txn_last set.
- R4: With incrementing addressing and a start address that is not a multiple of beats×width, the first transaction is at the start address with (boundary − start)/width beats. Here the boundary is the next multiple of beats×width, and txn_last is 0.
- R5: The second transaction of a split burst starts at the boundary address, carries the remaining beats, and has txn_last set. Every issued transaction has a nonzero beat count.
- R6: With fixed addressing, exactly one transaction is issued at the start address with the full beat count, whatever the alignment.
- R7: While txn_valid is 1 and txn_ready is 0, txn_valid, txn_addr and txn_beats hold their values into the next cycle.
- R8: In the cycle after the last transaction is accepted, done_valid is 1 for exactly one cycle. During that cycle, next_addr is start + beats×width for incrementing addressing and the start address for fixed addressing.
- R9: cmd_ready is 1 only while no command is in progress. A cmd_valid raised while a command is in progress neither alters nor adds to the transactions being issued.
- R10: A new command can be accepted in the same cycle that done_valid is 1. Its first transaction is then valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | Burst start address, aligned to the width |
| cmd_size | input | 2 | Transfer width code |
| cmd_len | input | LEN_CODE_W | Burst length code |
| cmd_incr | input | 1 | 1 = incrementing addressing, 0 = fixed |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction taken |
| txn_addr | output | ADDR_W | Transaction start address |
| txn_beats | output | LEN_CODE_W+6 | Transaction beat count |
| txn_last | output | 1 | Final transaction of the burst |
| done_valid | output | 1 | One-cycle pulse after the final transaction is taken |
| next_addr | output | ADDR_W | Address following the burst, valid with done_valid |

## Verification
Completing one burst and accepting the next command can happen in the same cycle. The completion pulse, with its next address, appears in the cycle where the idle state makes cmd_ready true again. The bench provokes this by driving each following command at the exact sample where it observes done_valid, so that acceptance and the pulse coincide. It judges the overlap by checking next_addr for the old burst in that cycle, and then checking that the pieces which follow match the new command's own expected split.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;
endpackage

// File: rtl/beat_decode.sv
module beat_decode #(
    parameter int LEN_CODE_W = 3,
    parameter int BEAT_W     = 9,
    parameter int BYTE_W     = 11
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic [1:0]            size,
    output logic [BEAT_W-1:0]     beats,
    output logic [BYTE_W-1:0]     bytes
);
    logic [LEN_CODE_W:0] shift_amt;

    always_comb begin
        shift_amt = {1'b0, len_code} + 1'b1;
        if (len_code == '0) begin
            beats = BEAT_W'(1);
        end else begin
            beats = BEAT_W'(1) << shift_amt;
        end
        bytes = BYTE_W'(beats) << size;
    end
endmodule

// File: rtl/boundary_calc.sv
module boundary_calc #(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 9,
    parameter int BYTE_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [BEAT_W-1:0] beats,
    input  logic [BYTE_W-1:0] bytes,
    input  logic              incr,
    output logic              split,
    output logic [BEAT_W-1:0] head_beats,
    output logic [BEAT_W-1:0] tail_beats,
    output logic [ADDR_W-1:0] tail_addr
);
    logic [BYTE_W-1:0] offset;
    logic [BYTE_W-1:0] head_bytes;
    logic [BYTE_W-1:0] head_count;

    always_comb begin
        offset     = addr[BYTE_W-1:0] & (bytes - 1'b1);
        split      = incr && (offset != '0);
        head_bytes = bytes - offset;
        head_count = head_bytes >> size;
        head_beats = split ? head_count[BEAT_W-1:0] : beats;
        tail_beats = beats - head_beats;
        tail_addr  = addr + ADDR_W'(head_bytes);
    end
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter
    import splitter_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_CODE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [1:0]              cmd_size,
    input  logic [LEN_CODE_W-1:0]   cmd_len,
    input  logic                    cmd_incr,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic [LEN_CODE_W+5:0]   txn_beats,
    output logic                    txn_last,
    output logic                    done_valid,
    output logic [ADDR_W-1:0]       next_addr
);
    localparam int BEAT_W = (1 << LEN_CODE_W) + 1;
    localparam int BYTE_W = BEAT_W + 2;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   cur_addr;
        logic [BEAT_W-1:0]   cur_beats;
        logic [ADDR_W-1:0]   tail_addr;
        logic [BEAT_W-1:0]   tail_beats;
        logic                split;
        logic                incr;
        logic [ADDR_W-1:0]   after_addr;
        logic                done;
    } split_state_t;

    split_state_t st_d, st_q;

    logic [BEAT_W-1:0] dec_beats;
    logic [BYTE_W-1:0] dec_bytes;
    logic              calc_split;
    logic [BEAT_W-1:0] calc_head_beats;
    logic [BEAT_W-1:0] calc_tail_beats;
    logic [ADDR_W-1:0] calc_tail_addr;

    beat_decode #(
        .LEN_CODE_W (LEN_CODE_W),
        .BEAT_W     (BEAT_W),
        .BYTE_W     (BYTE_W)
    ) u_decode (
        .len_code (cmd_len),
        .size     (cmd_size),
        .beats    (dec_beats),
        .bytes    (dec_bytes)
    );

    boundary_calc #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W),
        .BYTE_W (BYTE_W)
    ) u_calc (
        .addr       (cmd_addr),
        .size       (cmd_size),
        .beats      (dec_beats),
        .bytes      (dec_bytes),
        .incr       (cmd_incr),
        .split      (calc_split),
        .head_beats (calc_head_beats),
        .tail_beats (calc_tail_beats),
        .tail_addr  (calc_tail_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    st_d.phase      = PH_HEAD;
                    st_d.cur_addr   = cmd_addr;
                    st_d.cur_beats  = calc_head_beats;
                    st_d.tail_addr  = calc_tail_addr;
                    st_d.tail_beats = calc_tail_beats;
                    st_d.split      = calc_split;
                    st_d.incr       = cmd_incr;
                    st_d.after_addr = cmd_incr ? cmd_addr + ADDR_W'(dec_bytes) : cmd_addr;
                end
            end
            PH_HEAD: begin
                if (txn_ready) begin
                    if (st_q.split) begin
                        st_d.phase     = PH_TAIL;
                        st_d.cur_addr  = st_q.tail_addr;
                        st_d.cur_beats = st_q.tail_beats;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            PH_TAIL: begin
                if (txn_ready) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready  = (st_q.phase == PH_IDLE);
    assign txn_valid  = (st_q.phase != PH_IDLE);
    assign txn_addr   = st_q.cur_addr;
    assign txn_beats  = st_q.cur_beats;
    assign txn_last   = (st_q.phase == PH_TAIL) || !st_q.split;
    assign done_valid = st_q.done;
    assign next_addr  = st_q.after_addr;

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_beats));

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> txn_valid && !cmd_ready);

    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready && txn_last |=> done_valid);

    assert_fixed_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !st_q.incr |-> txn_last);

    assert_tail_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready && !txn_last |=> txn_valid && txn_last);

    assert_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_beats != '0);
endmodule

// File: tb/dma_burst_splitter_test.sv
module dma_burst_splitter_test;
    localparam int ADDR_W = 32;
    localparam int LCW    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [1:0]        cmd_size = '0;
    logic [LCW-1:0]    cmd_len = '0;
    logic              cmd_incr = 1'b0;
    logic              txn_valid;
    logic              txn_ready = 1'b0;
    logic [ADDR_W-1:0] txn_addr;
    logic [LCW+5:0]    txn_beats;
    logic              txn_last;
    logic              done_valid;
    logic [ADDR_W-1:0] next_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_burst_splitter #(.ADDR_W(ADDR_W), .LEN_CODE_W(LCW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .cmd_len(cmd_len), .cmd_incr(cmd_incr),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_beats(txn_beats), .txn_last(txn_last),
        .done_valid(done_valid), .next_addr(next_addr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int beats_of(input int code);
        return (code == 0) ? 1 : (1 << (code + 1));
    endfunction

    // Drives one command at the current negedge and follows it to its completion pulse.
    task automatic run_cmd(input logic [31:0] a_in, input int sz, input int lc, input bit inc,
                           input int ready_pct, input bit poke_busy);
        logic [31:0] a = a_in & ~((32'd1 << sz) - 1);
        int beats = beats_of(lc);
        int nbytes = beats << sz;
        int off = int'(a % nbytes);
        int n_exp = (inc && off != 0) ? 2 : 1;
        logic [31:0] ea [2];
        int eb [2];
        logic [31:0] enext = inc ? a + nbytes : a;
        int got = 0;
        int iter = 0;
        bit held = 1'b0;
        logic [31:0] h_addr = '0;
        int h_beats = 0;
        ea[0] = a;
        eb[0] = (n_exp == 2) ? (nbytes - off) >> sz : beats;
        ea[1] = a + nbytes - off;
        eb[1] = beats - eb[0];
        chk(cmd_ready == 1'b1, "R9 idle ready", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_addr = a; cmd_size = 2'(sz); cmd_len = 3'(lc); cmd_incr = inc;
        txn_ready = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(txn_valid == 1'b1, "R10 first piece valid after accept", txn_valid, 1);
        while (iter < 3000) begin
            iter++;
            if (poke_busy) begin
                if (iter == 1) begin
                    cmd_valid = 1'b1; cmd_addr = a + 32'h100; cmd_len = 3'd0;
                end else begin
                    cmd_valid = 1'b0;
                end
            end
            if (done_valid) begin
                chk(got == n_exp, "R8 done after all pieces", got, n_exp);
                chk(next_addr == enext, "R8 next_addr", next_addr, enext);
                chk(cmd_ready == 1'b1, "R10 ready with done", cmd_ready, 1);
                break;
            end
            if (txn_valid) begin
                chk(cmd_ready == 1'b0, "R9 busy not ready", cmd_ready, 0);
                if (held) begin
                    chk(txn_addr == h_addr, "R7 addr held", txn_addr, h_addr);
                    chk(int'(txn_beats) == h_beats, "R7 beats held", txn_beats, h_beats);
                end
                if (got >= n_exp) begin
                    chk(1'b0, "R9 extra transaction", got + 1, n_exp);
                    txn_ready = 1'b1;
                end else if (($urandom % 100) < ready_pct) begin
                    txn_ready = 1'b1;
                    held = 1'b0;
                    if (!inc) begin
                        chk(txn_addr == ea[got], "R6 fixed addr", txn_addr, ea[got]);
                        chk(int'(txn_beats) == eb[got], "R6 fixed beats", txn_beats, eb[got]);
                    end else if (n_exp == 1) begin
                        chk(txn_addr == ea[0], "R3 aligned addr", txn_addr, ea[0]);
                        chk(int'(txn_beats) == eb[0], "R3 aligned beats", txn_beats, eb[0]);
                    end else if (got == 0) begin
                        chk(txn_addr == ea[0], "R4 head addr", txn_addr, ea[0]);
                        chk(int'(txn_beats) == eb[0], "R4 head beats", txn_beats, eb[0]);
                    end else begin
                        chk(txn_addr == ea[1], "R5 tail addr", txn_addr, ea[1]);
                        chk(int'(txn_beats) == eb[1], "R5 tail beats", txn_beats, eb[1]);
                    end
                    chk(txn_last == (got == n_exp - 1), "R5 last flag", txn_last, got == n_exp - 1);
                    got++;
                end else begin
                    txn_ready = 1'b0;
                    held = 1'b1;
                    h_addr = txn_addr;
                    h_beats = int'(txn_beats);
                end
            end else begin
                txn_ready = 1'b0;
            end
            @(negedge clk);
        end
        txn_ready = 1'b0;
        if (iter >= 3000) chk(1'b0, "R8 no completion", 0, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 reset cmd_ready", cmd_ready, 1);
        chk(txn_valid == 1'b0, "R1 reset txn_valid", txn_valid, 0);
        chk(done_valid == 1'b0, "R1 reset done_valid", done_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R5: 16 words from an unaligned start split 7 + 9
        run_cmd(32'h0C00_0024, 2, 3, 1'b1, 100, 1'b0);
        // R3: aligned start, back-to-back with the previous done (R10)
        run_cmd(32'h0C00_0040, 2, 3, 1'b1, 60, 1'b0);
        // R6: fixed addressing, unaligned
        run_cmd(32'h0000_1236, 1, 7, 1'b0, 50, 1'b0);
        // R2: single byte, 256-word and halfword lengths
        run_cmd(32'h0000_0003, 0, 0, 1'b1, 100, 1'b0);
        run_cmd(32'h0000_0404, 2, 7, 1'b1, 100, 1'b0);
        run_cmd(32'h0000_00FE, 1, 1, 1'b1, 30, 1'b0);
        // R9: command poked while busy is ignored
        run_cmd(32'h0000_2010, 2, 2, 1'b1, 20, 1'b1);
        for (int i = 0; i < 300; i++) begin
            run_cmd($urandom, int'($urandom % 3), int'($urandom % 8), 1'(($urandom % 4) != 0),
                    int'(20 + $urandom % 81), 1'(($urandom % 8) == 0));
            if (($urandom % 3) == 0) @(negedge clk);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule